// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat burst of a synchronous burst memory. A burst begins when one of two active-low address strobes is seen on a rising clock edge. The processor-side strobe can be suppressed by a gating input. The controller-side strobe is never suppressed. When a burst begins, the block captures the external address and resets a two-bit beat counter. The low two address bits then come from a mix of the captured start bits and that counter.

An active-low advance input steps the counter once per clock. When advance is high, the address holds. The order-select input is captured together with the address. A low order-select gives linear wraparound order: the start plus the count, modulo four. A high order-select gives interleaved order: the start XOR the count. After reset the order is interleaved. The upper address bits stay fixed for the whole burst. The counter wraps inside the same four-word block. A new strobe that arrives in the middle of a burst restarts the burst at the new address.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, addr_out is all zeros and beat_idx is 0.
- R2: When proc_strobe_n is low and proc_gate is low at a rising edge, addr_in is captured. From the next cycle, addr_out equals the captured start address and beat_idx is 0.
- R3: When ctrl_strobe_n is low at a rising edge, addr_in is captured. This happens whatever the level of proc_gate.
- R4: When proc_gate is high, a low proc_strobe_n has no effect. If ctrl_strobe_n and adv_n are both high, addr_out and beat_idx keep their values.
- R5: An edge with no load and adv_n low adds 1 to beat_idx, modulo 4. An edge with no load and adv_n high leaves beat_idx unchanged.
- R6: If order_sel was 0 at the load edge, addr_out[1:0] equals (start[1:0] + beat_idx) mod 4.
- R7: If order_sel was 1 at the load edge, addr_out[1:0] equals start[1:0] XOR beat_idx.
- R8: addr_out[ADDR_W-1:2] equals the captured addr_in[ADDR_W-1:2] for the whole burst, including after the fourth advance wraps beat_idx back to 0.
- R9: A strobe in the middle of a burst restarts the burst at the new address. A load overrides an advance on the same edge.
- R10: When both strobes are low on the same edge, exactly one load of addr_in takes place. The processor strobe has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| proc_gate | input | 1 | High blocks the processor strobe |
| adv_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | 0 linear, 1 interleaved; captured at load |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Position in the burst, 0 to 3 |

## Verification
The sweep covers all four start offsets under both orders. Each burst runs five advances, so linear and interleaved sequences are told apart and the wrap back to the start beat is visible. Further cases cover the following:
- held advance cycles, which separate holding from stepping;
- a gated processor strobe, which must leave the state alone, against a controller strobe under the same gate, which must load;
- a restart in the middle of a burst while advance is low;
- both strobes on the same edge.

Upper address bits that differ from burst to burst expose any disturbance of the high part.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // low address bits for a given start offset, count and order
  function automatic beat_t beat_low(beat_t start, beat_t cnt, logic interleave);
    beat_t sum;
    sum = beat_t'(start + cnt);
    return interleave ? (start ^ cnt) : sum;
  endfunction
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic proc_gate,
  output logic proc_load,
  output logic ctrl_load,
  output logic load_evt
);
  logic proc_req;
  logic ctrl_req;

  assign proc_req  = !proc_strobe_n && !proc_gate;
  assign ctrl_req  = !ctrl_strobe_n;
  // processor side wins when both request on one edge
  assign proc_load = proc_req;
  assign ctrl_load = ctrl_req && !proc_req;
  assign load_evt  = proc_load || ctrl_load;

  // R10: never two load sources at once
  a_r10_single_src: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({proc_load, ctrl_load}));
  // R4: a gated processor strobe alone never loads
  a_r4_gate_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gate && ctrl_strobe_n) |-> !load_evt);
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  adv,
  output beat_t count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= '0;
    else if (adv)  count <= beat_t'(count + 1'b1);
  end

  // R9: a load clears the count even when advance is active
  a_r9_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == '0));
  // R5: advance steps the count by one and wraps
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> (count == beat_t'($past(count) + 1'b1)));
  // R5: no advance means the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(count));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              proc_gate,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_idx
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic            proc_load;
  logic            ctrl_load;
  logic            load_evt;
  logic [HI_W-1:0] base_hi;
  beat_t           base_lo;
  logic            mode_q;
  beat_t           count;

  burst_load_ctrl u_load (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .proc_gate     (proc_gate),
    .proc_load     (proc_load),
    .ctrl_load     (ctrl_load),
    .load_evt      (load_evt)
  );

  burst_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .adv   (!adv_n),
    .count (count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      mode_q  <= 1'b1;
    end else if (load_evt) begin
      base_hi <= addr_in[ADDR_W-1:BEAT_W];
      base_lo <= addr_in[BEAT_W-1:0];
      mode_q  <= order_sel;
    end
  end

  assign addr_out = {base_hi, beat_low(base_lo, count, mode_q)};
  assign beat_idx = count;

  // R8: upper bits change only through a load
  a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
  // R2 / R3: a load presents the start address on the next cycle
  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_out == $past(addr_in)));
  // R4: gated processor strobe with no other activity leaves the address alone
  a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gate && ctrl_strobe_n && adv_n) |=> $stable(addr_out));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_strobe_n = 1'b1;
  logic          ctrl_strobe_n = 1'b1;
  logic          proc_gate = 1'b0;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_idx;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .proc_gate(proc_gate), .adv_n(adv_n),
    .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out),
    .beat_idx(beat_idx)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] start, int k, logic il);
    int lo;
    if (il) lo = int'(start[1:0]) ^ (k % 4);
    else    lo = (int'(start[1:0]) + k) % 4;
    return {start[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(string req, logic [AW-1:0] exp_a, int exp_b);
    tests++;
    if (addr_out !== exp_a || int'(beat_idx) != exp_b) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat_idx, exp_a, exp_b);
    end
  endtask

  // one full clock: drive after negedge, sample at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_burst(bit use_ctrl, logic [AW-1:0] a, logic il);
    addr_in = a; order_sel = il;
    if (use_ctrl) ctrl_strobe_n = 1'b0; else proc_strobe_n = 1'b0;
    step();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    @(negedge clk);
    @(negedge clk);
    check("R1", '0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R7 / R8: all start offsets in both orders, five advances (wrap)
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        a = AW'((s * 37 + il * 1000 + 5) << 2) | AW'(s);
        start_burst((s % 2) == 1, a, il[0]);
        check((s % 2) == 1 ? "R3" : "R2", a, 0);
        adv_n = 1'b0;
        for (int k = 1; k <= 5; k++) begin
          step();
          check(il == 1 ? "R7" : "R6", expect_addr(a, k, il[0]), k % 4);
        end
        adv_n = 1'b1;
        step();
        check("R8", expect_addr(a, 5, il[0]), 1);
      end
    end

    // R5: hold while advance high
    a = 18'h2A5F6;
    start_burst(1'b0, a, 1'b0);
    adv_n = 1'b0; step(); adv_n = 1'b1;
    step(); step();
    check("R5", expect_addr(a, 1, 1'b0), 1);

    // R4: gated processor strobe ignored
    proc_gate = 1'b1; addr_in = 18'h01234; proc_strobe_n = 1'b0;
    step();
    proc_strobe_n = 1'b1;
    check("R4", expect_addr(a, 1, 1'b0), 1);

    // R3: controller strobe loads while gate high
    a = 18'h3C0C1;
    start_burst(1'b1, a, 1'b1);
    check("R3", a, 0);
    proc_gate = 1'b0;

    // R9: restart in the middle of a burst while advance low
    adv_n = 1'b0; step(); step();
    a = 18'h15552;
    addr_in = a; order_sel = 1'b0; proc_strobe_n = 1'b0;
    step();
    proc_strobe_n = 1'b1;
    check("R9", a, 0);
    step();
    check("R9", expect_addr(a, 1, 1'b0), 1);
    adv_n = 1'b1;

    // R10: both strobes on the same edge load once
    a = 18'h0FFF3;
    addr_in = a; order_sel = 1'b1;
    proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0;
    step();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
    check("R10", a, 0);
    adv_n = 1'b0; step(); adv_n = 1'b1;
    check("R10", expect_addr(a, 1, 1'b1), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule